// File: doc/BRIEF.md
# Dual-Density Floppy Interface Glue

This block sits between a host I/O bus and a single floppy disk controller core that can run in high-density or double-density mode. It decodes host accesses to four places. Two of them, the controller's status port and data port, are passed straight through to the core. The other two, a control register and a mode register, are held inside this block. It does not model the controller, the interrupt controller or the DMA engine; it only presents ports to them.

The control register drives the controller's drive-ready level. A rising edge on its top bit becomes a one-cycle reset pulse to the core. Setting its timer bit starts a one-shot timeout that raises the floppy interrupt.

The mode register has two bits. Bit 0 picks which of two address aliases (differing in address bit 4) is live for the status, data and control ports. Bit 1 picks the density of drives 0 and 1, and it also steers the interrupt and DMA request lines:
- High density: interrupt level 3 and DMA channel 2.
- Double density: interrupt level 2 and DMA channel 3.

Host reads of the control port return fixed configuration-switch bits plus a disk-present flag. Reads of the mode register return its two bits above a fixed pattern. Unused addresses read as all ones.

Top module: `fdd_bridge`

## Requirements
- R1: After reset the control and mode state are zero: `fdc_ready` is 0, `fdc_reset` is 0, drives 0 and 1 report double density (`drive_hd` bit = 0), and no interrupt is pending from the timer.
- R2: The status port (0x80/0x90), data port (0x82/0x92) and control port (0x84/0x94) respond only on the alias whose address bit 4 differs from mode bit 0. An access on the other alias raises no `fdc_cs`, changes no state, and reads 0xFF. A live status access drives `fdc_a0`=0, a live data access drives `fdc_a0`=1, and reads on either return `fdc_rdata`.
- R3: A live control write whose bit 7 is 1 while the stored bit 7 is 0 makes `fdc_reset` high for exactly the one cycle after the write edge; any other control write makes no pulse.
- R4: `fdc_ready` takes bit 6 of each live control write from the edge of that write.
- R5: Every live control write clears the timer interrupt and cancels a running count; if its bit 2 is 1 a new count starts and the timer interrupt rises TIMER_MS*CLK_KHZ clock edges after the write edge.
- R6: Drives 0 and 1 follow mode bit 1 (`drive_hd` bit = 1 for high density) from the edge of the mode write at address 0xBE; drives 2 and up always report high density.
- R7: A read of 0xBE returns 0xF8 OR mode bits [1:0]; the mode register has no alias.
- R8: A read of the live control port returns 0x64, with bit 4 also set when `disk_present` is 1.
- R9: With mode bit 1 set, the request source drives `pic_ir3` and `fdc_drq` drives `dma_req2`; with it clear they drive `pic_ir2` and `dma_req3`; the unselected lines stay 0. The request source is `fdc_irq` OR the timer interrupt.
- R10: A read of any address not listed above returns 0xFF.
- R11: Once raised, the timer interrupt stays high until the next live control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| fdc_cs | output | 1 | Access forwarded to controller core |
| fdc_a0 | output | 1 | Controller port index, 0 status, 1 data |
| fdc_wr | output | 1 | Forwarded write strobe |
| fdc_rd | output | 1 | Forwarded read strobe |
| fdc_wdata | output | 8 | Forwarded write data |
| fdc_rdata | input | 8 | Controller read data |
| fdc_reset | output | 1 | One-cycle controller reset pulse |
| fdc_ready | output | 1 | Drive-ready level to controller |
| drive_hd | output | NUM_DRIVES | Per-drive density, 1 high density |
| disk_present | input | 1 | A disk is inserted |
| fdc_irq | input | 1 | Controller interrupt request |
| fdc_drq | input | 1 | Controller DMA request |
| pic_ir2 | output | 1 | Interrupt level 2 |
| pic_ir3 | output | 1 | Interrupt level 3 |
| dma_req2 | output | 1 | DMA channel 2 request |
| dma_req3 | output | 1 | DMA channel 3 request |

## Verification
The assertions take for granted that the host never raises `bus_rd` and `bus_wr` in the same cycle, and that a write strobe lasts one cycle per access. They also assume reset is held for at least one clock edge before traffic starts. The stimulus drives every strobe for exactly one cycle, from the falling edge. It chooses reads or writes one at a time, so the two strobes never overlap. It keeps the timer bit clear in the random phase, so the routed interrupt comes from `fdc_irq` alone and can be predicted there.

// File: rtl/fdd_bridge_pkg.sv
package fdd_bridge_pkg;

   // Port offsets with the alias bit cleared; behaviour depends on ALIAS_BIT only.
   localparam logic [7:0] OFF_STATUS = 8'h80;
   localparam logic [7:0] OFF_DATA   = 8'h82;
   localparam logic [7:0] OFF_CTRL   = 8'h84;
   localparam logic [7:0] OFF_MODE   = 8'hBE;
   localparam int         ALIAS_BIT  = 4;

   // Control register bit positions
   localparam int CTL_RESET = 7;
   localparam int CTL_READY = 6;
   localparam int CTL_TIMER = 2;

   // Mode register bit positions
   localparam int MOD_ALIAS = 0;
   localparam int MOD_DENS  = 1;

   // Fixed switch bits returned from a control read, and the disk flag position
   localparam logic [7:0] CTL_RD_FIXED = 8'h64;
   localparam int         CTL_RD_DISK  = 4;
   localparam logic [5:0] MOD_RD_FIXED = 6'b111110;
   localparam logic [7:0] RD_IDLE      = 8'hFF;

   typedef struct packed {
      logic status;
      logic data;
      logic ctrl;
      logic mode;
   } fdd_sel_t;

   typedef enum logic {
      DENS_DOUBLE = 1'b0,
      DENS_HIGH   = 1'b1
   } fdd_dens_t;

endpackage

// File: rtl/fdd_bridge_decode.sv
module fdd_bridge_decode
   import fdd_bridge_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              alias_sel,
   output fdd_sel_t          sel
);

   localparam logic [ADDR_W-1:0] ALIAS_MASK = ADDR_W'(1) << ALIAS_BIT;

   initial begin
      assert (ADDR_W >= 8) else $error("fdd_bridge_decode: ADDR_W must be at least 8");
   end

   logic [ADDR_W-1:0] addr_folded;
   logic              alias_live;

   assign addr_folded = addr & ~ALIAS_MASK;
   assign alias_live  = addr[ALIAS_BIT] != alias_sel;

   always_comb begin
      sel        = '0;
      sel.status = alias_live && (addr_folded == ADDR_W'(OFF_STATUS));
      sel.data   = alias_live && (addr_folded == ADDR_W'(OFF_DATA));
      sel.ctrl   = alias_live && (addr_folded == ADDR_W'(OFF_CTRL));
      sel.mode   = (addr == ADDR_W'(OFF_MODE));
   end

endmodule

// File: rtl/fdd_bridge_oneshot.sv
module fdd_bridge_oneshot #(
   parameter int CYCLES = 1000,
   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic arm,
   output logic expired
);

   initial begin
      assert (CYCLES >= 1) else $error("fdd_bridge_oneshot: CYCLES must be positive");
   end

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         expired <= 1'b0;
      end else if (restart) begin
         cnt_q   <= LOAD;
         run_q   <= arm;
         expired <= 1'b0;
      end else if (run_q) begin
         if (cnt_q == '0) begin
            run_q   <= 1'b0;
            expired <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R11: a raised flag survives until a restart
   assert_flag_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !restart) |=> expired);
   // R5: the flag only rises at the end of a running count
   assert_rise_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(run_q));
   // R5: a restart always clears the flag
   assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expired);
   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= LOAD));

endmodule

// File: rtl/fdd_bridge_route.sv
module fdd_bridge_route
   import fdd_bridge_pkg::*;
(
   input  fdd_dens_t dens,
   input  logic      irq_src,
   input  logic      drq_src,
   output logic      ir2,
   output logic      ir3,
   output logic      dreq2,
   output logic      dreq3
);

   always_comb begin
      ir2   = 1'b0;
      ir3   = 1'b0;
      dreq2 = 1'b0;
      dreq3 = 1'b0;
      unique case (dens)
         DENS_HIGH: begin
            ir3   = irq_src;
            dreq2 = drq_src;
         end
         default: begin
            ir2   = irq_src;
            dreq3 = drq_src;
         end
      endcase
   end

endmodule

// File: rtl/fdd_bridge.sv
module fdd_bridge
   import fdd_bridge_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_DRIVES = 4,
   parameter int CLK_KHZ    = 250000,
   parameter int TIMER_MS   = 100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   output logic                  fdc_cs,
   output logic                  fdc_a0,
   output logic                  fdc_wr,
   output logic                  fdc_rd,
   output logic [7:0]            fdc_wdata,
   input  logic [7:0]            fdc_rdata,
   output logic                  fdc_reset,
   output logic                  fdc_ready,
   output logic [NUM_DRIVES-1:0] drive_hd,
   input  logic                  disk_present,
   input  logic                  fdc_irq,
   input  logic                  fdc_drq,
   output logic                  pic_ir2,
   output logic                  pic_ir3,
   output logic                  dma_req2,
   output logic                  dma_req3
);

   localparam int TIMER_CYCLES = CLK_KHZ * TIMER_MS;
   localparam int PAIR_DRIVES  = 2;

   initial begin
      assert (NUM_DRIVES >= PAIR_DRIVES) else $error("fdd_bridge: NUM_DRIVES below 2");
      assert (CLK_KHZ > 0 && TIMER_MS > 0) else $error("fdd_bridge: timer period must be positive");
   end

   fdd_sel_t  sel;
   logic [1:0] mode_q;
   logic       ctl_top_q;
   logic       ready_q;
   logic       pulse_q;
   logic       ctrl_wr;
   logic       mode_wr;
   logic       tmr_irq;
   fdd_dens_t  dens;

   fdd_bridge_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr      (bus_addr),
      .alias_sel (mode_q[MOD_ALIAS]),
      .sel       (sel)
   );

   assign ctrl_wr = bus_wr && sel.ctrl;
   assign mode_wr = bus_wr && sel.mode;
   assign dens    = fdd_dens_t'(mode_q[MOD_DENS]);

   // Forwarding to the controller core
   assign fdc_cs    = (sel.status || sel.data) && (bus_rd || bus_wr);
   assign fdc_a0    = sel.data;
   assign fdc_wr    = fdc_cs && bus_wr;
   assign fdc_rd    = fdc_cs && bus_rd;
   assign fdc_wdata = bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= '0;
         ctl_top_q <= 1'b0;
         ready_q   <= 1'b0;
         pulse_q   <= 1'b0;
      end else begin
         pulse_q <= ctrl_wr && bus_wdata[CTL_RESET] && !ctl_top_q;
         if (ctrl_wr) begin
            ctl_top_q <= bus_wdata[CTL_RESET];
            ready_q   <= bus_wdata[CTL_READY];
         end
         if (mode_wr) begin
            mode_q <= bus_wdata[1:0];
         end
      end
   end

   assign fdc_reset = pulse_q;
   assign fdc_ready = ready_q;

   fdd_bridge_oneshot #(.CYCLES(TIMER_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctrl_wr),
      .arm     (bus_wdata[CTL_TIMER]),
      .expired (tmr_irq)
   );

   fdd_bridge_route u_route (
      .dens    (dens),
      .irq_src (fdc_irq || tmr_irq),
      .drq_src (fdc_drq),
      .ir2     (pic_ir2),
      .ir3     (pic_ir3),
      .dreq2   (dma_req2),
      .dreq3   (dma_req3)
   );

   // Per-drive density: the first pair follows the mode, the rest are fixed
   for (genvar gi = 0; gi < NUM_DRIVES; gi++) begin : g_drive
      if (gi < PAIR_DRIVES) begin : g_pair
         assign drive_hd[gi] = (dens == DENS_HIGH);
      end else begin : g_fixed
         assign drive_hd[gi] = 1'b1;
      end
   end

   // Host read path
   always_comb begin
      bus_rdata = RD_IDLE;
      if (sel.status || sel.data) begin
         bus_rdata = fdc_rdata;
      end else if (sel.ctrl) begin
         bus_rdata = CTL_RD_FIXED;
         bus_rdata[CTL_RD_DISK] = disk_present;
      end else if (sel.mode) begin
         bus_rdata = {MOD_RD_FIXED, mode_q};
      end
   end

   // R3: the controller reset is a single-cycle pulse
   assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fdc_reset |=> !fdc_reset);
   // R2: the dead alias never reaches the controller
   assert_dead_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && (bus_addr[ALIAS_BIT] == mode_q[MOD_ALIAS])) |-> !fdc_cs);
   // R4: ready follows the written bit
   assert_ready_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (fdc_ready == $past(bus_wdata[CTL_READY])));
   // R6: drive 0 density follows the written mode bit
   assert_density_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (drive_hd[0] == $past(bus_wdata[MOD_DENS])));
   // R9: a DMA request lands on exactly one channel
   assert_drq_routed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fdc_drq |-> (dma_req2 != dma_req3));
   // R9: no interrupt appears without a source
   assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fdc_irq && !tmr_irq) |-> !(pic_ir2 || pic_ir3));

endmodule

// File: tb/fdd_bridge_tb.sv
module fdd_bridge_tb;

   localparam int ADDR_W  = 8;
   localparam int NDRV    = 4;
   localparam int CLK_KHZ = 10;
   localparam int TMR_MS  = 5;
   localparam int TCYC    = CLK_KHZ * TMR_MS;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [7:0]      bus_wdata = '0;
   logic [7:0]      bus_rdata;
   logic            fdc_cs, fdc_a0, fdc_wr, fdc_rd;
   logic [7:0]      fdc_wdata;
   logic [7:0]      fdc_rdata = 8'h00;
   logic            fdc_reset, fdc_ready;
   logic [NDRV-1:0] drive_hd;
   logic            disk_present = 1'b0;
   logic            fdc_irq = 1'b0;
   logic            fdc_drq = 1'b0;
   logic            pic_ir2, pic_ir3, dma_req2, dma_req3;

   int errors = 0;
   int checks = 0;

   logic [1:0] m_mode = 2'b00;
   logic       m_top  = 1'b0;
   logic       m_rdy  = 1'b0;

   always #2 clk = ~clk;

   fdd_bridge #(.ADDR_W(ADDR_W), .NUM_DRIVES(NDRV), .CLK_KHZ(CLK_KHZ), .TIMER_MS(TMR_MS)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fdc_cs(fdc_cs), .fdc_a0(fdc_a0),
      .fdc_wr(fdc_wr), .fdc_rd(fdc_rd), .fdc_wdata(fdc_wdata), .fdc_rdata(fdc_rdata),
      .fdc_reset(fdc_reset), .fdc_ready(fdc_ready), .drive_hd(drive_hd),
      .disk_present(disk_present), .fdc_irq(fdc_irq), .fdc_drq(fdc_drq),
      .pic_ir2(pic_ir2), .pic_ir3(pic_ir3), .dma_req2(dma_req2), .dma_req3(dma_req3)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic live(input logic [7:0] a, input logic [1:0] md);
      return a[4] != md[0];
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [1:0] md,
                                           input logic dk, input logic [7:0] frd);
      logic [7:0] f;
      f = a & 8'hEF;
      if ((f == 8'h80 || f == 8'h82) && live(a, md)) return frd;
      if (f == 8'h84 && live(a, md)) return 8'h64 | {3'b0, dk, 4'b0};
      if (a == 8'hBE) return 8'hF8 | {6'b0, md};
      return 8'hFF;
   endfunction

   function automatic logic [3:0] exp_route(input logic [1:0] md, input logic irq, input logic drq);
      // {pic_ir2, pic_ir3, dma_req2, dma_req3}
      return md[1] ? {1'b0, irq, drq, 1'b0} : {irq, 1'b0, 1'b0, drq};
   endfunction

   // Write: drive at falling edge, captured at next rising edge, returns after it
   task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic exp_pulse);
      logic is_ctrl;
      exp_pulse = 1'b0;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      is_ctrl = ((a & 8'hEF) == 8'h84) && live(a, m_mode);
      if (is_ctrl) begin
         exp_pulse = d[7] && !m_top;
         m_top = d[7];
         m_rdy = d[6];
      end
      if (a == 8'hBE) m_mode = d[1:0];
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      logic [7:0] f;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      fdc_rdata = 8'($urandom);
      #1;
      chk(bus_rdata, exp_read(a, m_mode, disk_present, fdc_rdata), tag);
      f = a & 8'hEF;
      if ((f == 8'h80 || f == 8'h82) && live(a, m_mode)) begin
         chk({fdc_cs, fdc_rd, fdc_a0}, {2'b11, f == 8'h82}, {tag, " fwd R2"});
      end else begin
         chk(fdc_cs, 1'b0, {tag, " no-fwd R2"});
      end
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      report();
      $finish;
   end

   initial begin
      logic p;
      logic [7:0] a, d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk({fdc_ready, fdc_reset, drive_hd}, {2'b00, 4'b1100}, "R1 reset outputs");
      fdc_irq = 1'b1;
      #1;
      chk({pic_ir2, pic_ir3}, 2'b10, "R1 double-density routing at reset");
      fdc_irq = 1'b0;
      rd(8'hBE, "R1 R7 mode after reset");

      // R2: dead alias (mode bit0=0 -> addr bit4=0 dead)
      rd(8'h80, "R2 dead status");
      rd(8'h90, "R2 live status");
      rd(8'h92, "R2 live data");
      wr(8'h84, 8'hC0, p);
      #1;
      chk({fdc_ready, fdc_reset}, 2'b00, "R2 dead control write ignored");
      // R3 R4: live control write with bit 7 rising
      wr(8'h94, 8'hC0, p);
      #1;
      chk({fdc_reset, fdc_ready}, {p, 1'b1}, "R3 R4 pulse and ready");
      @(negedge clk); #1;
      chk(fdc_reset, 1'b0, "R3 pulse one cycle");
      wr(8'h94, 8'h80, p);
      #1;
      chk({fdc_reset, fdc_ready}, 2'b00, "R3 no pulse when bit7 already set");
      // R8
      disk_present = 1'b1;
      rd(8'h94, "R8 control read with disk");
      disk_present = 1'b0;
      rd(8'h94, "R8 control read no disk");
      rd(8'h84, "R2 dead control read");
      // R6 R7 R9: switch mode
      wr(8'hBE, 8'h03, p);
      #1;
      chk(drive_hd, 4'b1111, "R6 high density");
      rd(8'hBE, "R7 mode read high");
      rd(8'h80, "R2 swapped alias live");
      rd(8'h90, "R2 swapped alias dead");
      fdc_irq = 1'b1; fdc_drq = 1'b1; #1;
      chk({pic_ir2, pic_ir3, dma_req2, dma_req3}, 4'b0110, "R9 high-density routing");
      fdc_irq = 1'b0; fdc_drq = 1'b0;
      wr(8'hBE, 8'h00, p);
      #1;
      chk(drive_hd, 4'b1100, "R6 back to double density");
      // R10
      rd(8'h00, "R10 undecoded 00");
      rd(8'hAE, "R10 undecoded AE");
      rd(8'h86, "R10 undecoded 86");

      // Random phase, timer bit kept clear
      for (int i = 0; i < 300; i++) begin
         int op;
         op = int'($urandom_range(0, 3));
         case (op)
            0: begin
               d = 8'($urandom);
               wr(8'hBE, d, p);
               #1;
               chk(drive_hd, {2'b11, {2{m_mode[1]}}}, "R6 random mode write");
            end
            1: begin
               d = 8'($urandom) & 8'hFB;
               a = $urandom_range(0, 1) ? 8'h84 : 8'h94;
               wr(a, d, p);
               #1;
               chk({fdc_reset, fdc_ready}, {p, m_rdy}, "R3 R4 random control write");
            end
            2: begin
               case ($urandom_range(0, 7))
                  0: a = 8'h80; 1: a = 8'h90; 2: a = 8'h82; 3: a = 8'h92;
                  4: a = 8'h84; 5: a = 8'h94; 6: a = 8'hBE;
                  default: a = 8'($urandom);
               endcase
               disk_present = 1'($urandom);
               rd(a, "R2 R7 R8 R10 random read");
            end
            default: begin
               @(negedge clk);
               fdc_irq = 1'($urandom); fdc_drq = 1'($urandom);
               #1;
               chk({pic_ir2, pic_ir3, dma_req2, dma_req3},
                   exp_route(m_mode, fdc_irq, fdc_drq), "R9 random routing");
               fdc_irq = 1'b0; fdc_drq = 1'b0;
            end
         endcase
      end

      // R5 R11: timer, mode forced to known state
      wr(8'hBE, 8'h00, p);
      wr(8'h94, 8'h04, p);
      repeat (TCYC - 1) @(negedge clk);
      #1;
      chk(pic_ir2, 1'b0, "R5 timer not yet expired");
      @(negedge clk); #1;
      chk(pic_ir2, 1'b1, "R5 timer expired");
      repeat (20) @(negedge clk);
      #1;
      chk(pic_ir2, 1'b1, "R11 timer interrupt held");
      wr(8'h84, 8'h00, p);
      #1;
      chk(pic_ir2, 1'b1, "R11 dead-alias write keeps interrupt");
      wr(8'h94, 8'h00, p);
      #1;
      chk(pic_ir2, 1'b0, "R5 control write clears interrupt");
      wr(8'h94, 8'h04, p);
      repeat (TCYC / 2) @(negedge clk);
      wr(8'h94, 8'h00, p);
      repeat (TCYC + 10) @(negedge clk);
      #1;
      chk(pic_ir2, 1'b0, "R5 cancelled timer stays quiet");
      wr(8'hBE, 8'h02, p);
      wr(8'h94, 8'h04, p);
      repeat (TCYC) @(negedge clk);
      #1;
      chk({pic_ir2, pic_ir3}, 2'b01, "R5 R9 timer interrupt routed to level 3");
      wr(8'h94, 8'h00, p);

      report();
      $finish;
   end

endmodule